// File: doc/BRIEF.md
# Completion Interrupt Pending Controller

This block collects transfer-completion reports from a data-movement engine and turns them into interrupt requests. Each report carries a 6-bit completion code, which picks one of 64 pending bits. It also carries two flags that say whether the report is a final or an intermediate completion, and the two interrupt-enable options from the transfer's parameter set. A report sets its pending bit only when the kind of completion it reports has its option enabled. The 64 pending bits are shown as a low word (codes 0 to 31) and a high word (codes 32 to 63).

One global interrupt line fires when any pending bit is set and its global enable bit is also set. Four shadow-region lines use the same pending and enable bits, and each one is further gated by that region's own 64-bit access mask. Software clears pending bits by writing ones to a half-word. It writes enables and masks one half-word at a time. Pending bits persist until they are cleared. Software can also request a re-evaluation: the interrupt outputs drop for one cycle, so a fresh rising edge appears if unmasked bits are still pending.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: After reset, `pend_lo`, `pend_hi`, `irq_global` and `irq_region` are all zero. All enables and masks are also zero.
- R2: A report with `cmp_valid`=1 that is accepted sets pending bit `cmp_code`. Codes 0 to 31 appear at `pend_lo[cmp_code]` one cycle after the report.
- R3: Codes 32 to 63 set `pend_hi[cmp_code-32]`. For example, code 63 sets `pend_hi[31]` and leaves `pend_lo[0]` unchanged.
- R4: A report is accepted only when (`cmp_final` and `opt_final_ien`) or (`cmp_inter` and `opt_inter_ien`) holds. Any other report leaves the pending bits unchanged.
- R5: A clear with `clr_we`=1 clears the pending bits in the half selected by `clr_hi` (0 selects low, 1 selects high) at every position where `clr_data` holds a 1. Every other bit keeps its value.
- R6: When an accepted report and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: `irq_global` is 1 exactly when some pending bit has its global enable bit set. The only exception is the blanking cycle described in R10.
- R8: `irq_region[r]` is 1 exactly when some pending bit has both its global enable bit and its bit in region r's access mask set. The same R10 exception applies.
- R9: Pending bits never clear without a clear write. The interrupt outputs are level signals that stay high while the condition holds.
- R10: In the cycle after `reeval` is sampled high, `irq_global` and every `irq_region` line are 0. In the following cycle they again follow R7 and R8.
- R11: `ien_we` writes `ien_data` into the enable half selected by `ien_hi`. `mask_we` writes `mask_data` into the half, selected by `mask_hi`, of the mask of region `mask_sel`. The other half and the other regions are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion report valid |
| cmp_code | input | 6 | Completion code, selects the pending bit |
| cmp_final | input | 1 | Report is a final completion |
| cmp_inter | input | 1 | Report is an intermediate completion |
| opt_final_ien | input | 1 | Final-completion interrupt option from the parameter set |
| opt_inter_ien | input | 1 | Intermediate-completion interrupt option from the parameter set |
| clr_we | input | 1 | Write-one-to-clear strobe for the pending bits |
| clr_hi | input | 1 | Clear targets the high half |
| clr_data | input | 32 | Bits to clear |
| ien_we | input | 1 | Global enable write strobe |
| ien_hi | input | 1 | Enable write targets the high half |
| ien_data | input | 32 | Enable write data |
| mask_we | input | 1 | Region access mask write strobe |
| mask_sel | input | 2 | Region index for the mask write |
| mask_hi | input | 1 | Mask write targets the high half |
| mask_data | input | 32 | Mask write data |
| reeval | input | 1 | Re-evaluation request pulse |
| pend_lo | output | 32 | Pending bits for codes 0 to 31 |
| pend_hi | output | 32 | Pending bits for codes 32 to 63 |
| irq_global | output | 1 | Global interrupt level |
| irq_region | output | 4 | Shadow-region interrupt levels |

## Verification
Reports, clears, and enable or mask writes are registered at one clock edge. Their effect on the pending words and the interrupt lines is therefore visible one cycle later. A `reeval` pulse forces the lines low in exactly that next cycle, and they recover one cycle after that. The bench drives every input just after a falling edge and samples just before the next falling edge, so each result is read one rising edge after its stimulus. For the recovery after a re-evaluation, the bench samples a second time, one further edge later.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CIC_CODE_W = 6;
  localparam int CIC_BITS   = 1 << CIC_CODE_W;
  localparam int CIC_HALF   = CIC_BITS / 2;

  typedef logic [CIC_BITS-1:0] cic_vec_t;
  typedef logic [CIC_HALF-1:0] cic_half_t;

  // one-hot vector for a completion code
  function automatic cic_vec_t cic_onehot(input logic [CIC_CODE_W-1:0] code);
    cic_vec_t v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  // place a half word into the low or high half of a full vector
  function automatic cic_vec_t cic_place(input logic hi, input cic_half_t d);
    return hi ? {d, cic_half_t'(0)} : {cic_half_t'(0), d};
  endfunction

  // replace one half of a full vector
  function automatic cic_vec_t cic_merge(input cic_vec_t old, input logic hi, input cic_half_t d);
    return hi ? {d, old[CIC_HALF-1:0]} : {old[CIC_BITS-1:CIC_HALF], d};
  endfunction

  // report acceptance by the interrupt options
  function automatic logic cic_accept(input logic fin, input logic inter,
                                      input logic opt_f, input logic opt_i);
    return (fin & opt_f) | (inter & opt_i);
  endfunction
endpackage

// File: rtl/cic_pend_reg.sv
module cic_pend_reg
  import cic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cic_vec_t set_vec,
  input  cic_vec_t clr_vec,
  output cic_vec_t pend
);
  // set has priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/cic_enable_bank.sv
module cic_enable_bank
  import cic_pkg::*;
#(
  parameter int N_REGIONS = 4,
  localparam int SEL_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ien_we,
  input  logic                           ien_hi,
  input  cic_half_t                      ien_data,
  input  logic                           mask_we,
  input  logic [SEL_W-1:0]               mask_sel,
  input  logic                           mask_hi,
  input  cic_half_t                      mask_data,
  output cic_vec_t                       ien,
  output logic [N_REGIONS-1:0][CIC_BITS-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ien <= '0;
    else if (ien_we) ien <= cic_merge(ien, ien_hi, ien_data);
  end

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rst_n)
        mask[r] <= '0;
      else if (mask_we && (32'(mask_sel) == r))
        mask[r] <= cic_merge(mask[r], mask_hi, mask_data);
    end
  end
endmodule

// File: rtl/cic_irq_gen.sv
module cic_irq_gen
  import cic_pkg::*;
#(
  parameter int N_REGIONS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  cic_vec_t                           pend,
  input  cic_vec_t                           ien,
  input  logic [N_REGIONS-1:0][CIC_BITS-1:0] mask,
  input  logic                               reeval,
  output logic                               blank,
  output logic                               irq_global,
  output logic [N_REGIONS-1:0]               irq_region
);
  logic     blank_q;
  cic_vec_t live;

  always_ff @(posedge clk) begin
    if (!rst_n) blank_q <= 1'b0;
    else        blank_q <= reeval;
  end

  assign blank      = blank_q;
  assign live       = pend & ien;
  assign irq_global = (|live) & ~blank_q;

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_line
    assign irq_region[r] = (|(live & mask[r])) & ~blank_q;
  end
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
  import cic_pkg::*;
#(
  parameter int N_REGIONS = 4,
  localparam int SEL_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmp_valid,
  input  logic [CIC_CODE_W-1:0] cmp_code,
  input  logic                  cmp_final,
  input  logic                  cmp_inter,
  input  logic                  opt_final_ien,
  input  logic                  opt_inter_ien,
  input  logic                  clr_we,
  input  logic                  clr_hi,
  input  logic [CIC_HALF-1:0]   clr_data,
  input  logic                  ien_we,
  input  logic                  ien_hi,
  input  logic [CIC_HALF-1:0]   ien_data,
  input  logic                  mask_we,
  input  logic [SEL_W-1:0]      mask_sel,
  input  logic                  mask_hi,
  input  logic [CIC_HALF-1:0]   mask_data,
  input  logic                  reeval,
  output logic [CIC_HALF-1:0]   pend_lo,
  output logic [CIC_HALF-1:0]   pend_hi,
  output logic                  irq_global,
  output logic [N_REGIONS-1:0]  irq_region
);
  // named internal events for the checker
  logic     accept;
  cic_vec_t set_vec;
  cic_vec_t clr_vec;
  cic_vec_t pend_all;
  cic_vec_t ien_all;
  logic [N_REGIONS-1:0][CIC_BITS-1:0] mask_all;
  logic     reeval_blank;

  assign accept  = cmp_valid & cic_accept(cmp_final, cmp_inter, opt_final_ien, opt_inter_ien);
  assign set_vec = accept ? cic_onehot(cmp_code) : '0;
  assign clr_vec = clr_we ? cic_place(clr_hi, clr_data) : '0;

  cic_pend_reg u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend    (pend_all)
  );

  cic_enable_bank #(.N_REGIONS(N_REGIONS)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien_we    (ien_we),
    .ien_hi    (ien_hi),
    .ien_data  (ien_data),
    .mask_we   (mask_we),
    .mask_sel  (mask_sel),
    .mask_hi   (mask_hi),
    .mask_data (mask_data),
    .ien       (ien_all),
    .mask      (mask_all)
  );

  cic_irq_gen #(.N_REGIONS(N_REGIONS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend_all),
    .ien        (ien_all),
    .mask       (mask_all),
    .reeval     (reeval),
    .blank      (reeval_blank),
    .irq_global (irq_global),
    .irq_region (irq_region)
  );

  assign pend_lo = pend_all[CIC_HALF-1:0];
  assign pend_hi = pend_all[CIC_BITS-1:CIC_HALF];
endmodule

// File: rtl/cic_checker.sv
module cic_checker
  import cic_pkg::*;
#(
  parameter int N_REGIONS = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cmp_valid,
  input logic [CIC_CODE_W-1:0]              cmp_code,
  input logic                               accept,
  input logic                               clr_we,
  input cic_vec_t                           clr_vec,
  input logic [CIC_HALF-1:0]                pend_lo,
  input logic [CIC_HALF-1:0]                pend_hi,
  input cic_vec_t                           ien_all,
  input logic [N_REGIONS-1:0][CIC_BITS-1:0] mask_all,
  input logic                               reeval,
  input logic                               reeval_blank,
  input logic                               irq_global,
  input logic [N_REGIONS-1:0]               irq_region
);
  cic_vec_t pend_w;
  assign pend_w = {pend_hi, pend_lo};

  // R2, R3, R6: an accepted report leaves its code's bit set, even under a clear
  a_r2_code_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pend_w[$past(cmp_code)]);

  // R4: without an accepted report or a clear, the pending bits do not move
  a_r4_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clr_we) |=> $stable(pend_w));

  // R5: cleared bits are zero when no report arrives at the same time
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !cmp_valid) |=> ((pend_w & $past(clr_vec)) == '0));

  // R9: no bit drops without a clear write
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pend_w & $past(pend_w)) == $past(pend_w)));

  // R7: global line follows pending and enable outside the blanking cycle
  a_r7_global_level: assert property (@(posedge clk) disable iff (!rst_n)
    !reeval_blank |-> (irq_global == (|(pend_w & ien_all))));

  // R10: a re-evaluation request blanks every line in the next cycle
  a_r10_blank: assert property (@(posedge clk) disable iff (!rst_n)
    reeval |=> (!irq_global && (irq_region == '0)));

  // R8: each region line is gated by its access mask
  for (genvar r = 0; r < N_REGIONS; r++) begin : g_chk
    a_r8_region_level: assert property (@(posedge clk) disable iff (!rst_n)
      !reeval_blank |-> (irq_region[r] == (|(pend_w & ien_all & mask_all[r]))));
  end
endmodule

bind cmpl_irq_ctrl cic_checker #(.N_REGIONS(N_REGIONS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_valid    (cmp_valid),
  .cmp_code     (cmp_code),
  .accept       (accept),
  .clr_we       (clr_we),
  .clr_vec      (clr_vec),
  .pend_lo      (pend_lo),
  .pend_hi      (pend_hi),
  .ien_all      (ien_all),
  .mask_all     (mask_all),
  .reeval       (reeval),
  .reeval_blank (reeval_blank),
  .irq_global   (irq_global),
  .irq_region   (irq_region)
);

// File: tb/sim_cmpl_irq_ctrl.sv
module sim_cmpl_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 0, cmp_final = 0, cmp_inter = 0;
  logic        opt_final_ien = 0, opt_inter_ien = 0;
  logic [5:0]  cmp_code = '0;
  logic        clr_we = 0, clr_hi = 0, ien_we = 0, ien_hi = 0, mask_we = 0, mask_hi = 0;
  logic [31:0] clr_data = '0, ien_data = '0, mask_data = '0;
  logic [1:0]  mask_sel = '0;
  logic        reeval = 0;
  logic [31:0] pend_lo, pend_hi;
  logic        irq_global;
  logic [NR-1:0] irq_region;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side model, built from the requirements
  logic [63:0] m_pend = '0;
  logic [63:0] m_ien  = '0;
  logic [63:0] m_mask [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpl_irq_ctrl #(.N_REGIONS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
    .cmp_final(cmp_final), .cmp_inter(cmp_inter), .opt_final_ien(opt_final_ien),
    .opt_inter_ien(opt_inter_ien), .clr_we(clr_we), .clr_hi(clr_hi), .clr_data(clr_data),
    .ien_we(ien_we), .ien_hi(ien_hi), .ien_data(ien_data), .mask_we(mask_we),
    .mask_sel(mask_sel), .mask_hi(mask_hi), .mask_data(mask_data), .reeval(reeval),
    .pend_lo(pend_lo), .pend_hi(pend_hi), .irq_global(irq_global), .irq_region(irq_region)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_glob();
    return |(m_pend & m_ien);
  endfunction

  function automatic logic [NR-1:0] exp_reg();
    logic [NR-1:0] v;
    for (int r = 0; r < NR; r++) v[r] = |(m_pend & m_ien & m_mask[r]);
    return v;
  endfunction

  task automatic check_all(input string req);
    chk({req, " pend"}, {pend_hi, pend_lo}, m_pend);
    chk({req, " irq_global"}, 64'(irq_global), 64'(exp_glob()));
    chk({req, " irq_region"}, 64'(irq_region), 64'(exp_reg()));
  endtask

  // one report; ff/ii are the flags, of/oi the options
  task automatic report(input logic [5:0] code, input logic ff, input logic ii,
                        input logic of, input logic oi);
    cmp_valid = 1; cmp_code = code; cmp_final = ff; cmp_inter = ii;
    opt_final_ien = of; opt_inter_ien = oi;
    @(negedge clk);
    cmp_valid = 0; cmp_final = 0; cmp_inter = 0;
    if ((ff && of) || (ii && oi)) m_pend[code] = 1'b1;
  endtask

  task automatic write_ien(input logic hi, input logic [31:0] d);
    ien_we = 1; ien_hi = hi; ien_data = d;
    @(negedge clk);
    ien_we = 0;
    if (hi) m_ien[63:32] = d; else m_ien[31:0] = d;
  endtask

  task automatic write_mask(input int r, input logic hi, input logic [31:0] d);
    mask_we = 1; mask_sel = 2'(r); mask_hi = hi; mask_data = d;
    @(negedge clk);
    mask_we = 0;
    if (hi) m_mask[r][63:32] = d; else m_mask[r][31:0] = d;
  endtask

  task automatic t_reset();
    check_all("R1 reset");
  endtask

  task automatic t_low_code();
    report(6'd5, 1, 0, 1, 0);
    check_all("R2 code 5");
    chk("R2 pend_lo bit5", 64'(pend_lo), 64'h20);
  endtask

  task automatic t_high_code();
    report(6'd63, 1, 0, 1, 0);
    chk("R3 pend_hi bit31", 64'(pend_hi), 64'h8000_0000);
    chk("R3 pend_lo bit0 untouched", 64'(pend_lo[0]), 64'd0);
    report(6'd32, 0, 1, 0, 1);
    check_all("R3 code 32");
  endtask

  task automatic t_gating();
    report(6'd7, 1, 0, 0, 1);
    check_all("R4 final without option");
    report(6'd8, 0, 1, 1, 0);
    check_all("R4 intermediate without option");
    report(6'd9, 0, 1, 0, 1);
    check_all("R4 intermediate with option");
    chk("R4 bit9", 64'(pend_lo[9]), 64'd1);
  endtask

  task automatic t_enables();
    write_ien(0, 32'h0000_0020);
    check_all("R7 R11 enable low bit5");
    write_mask(2, 1, 32'h8000_0000);
    check_all("R8 mask hi no enable yet");
    write_ien(1, 32'h8000_0000);
    check_all("R8 R11 region2 code63");
    chk("R8 region2 only", 64'(irq_region), 64'h4);
    write_mask(0, 0, 32'h0000_0200);
    check_all("R8 region0 bit9 not enabled");
    write_ien(0, 32'h0000_0220);
    check_all("R8 region0 bit9 enabled");
  endtask

  task automatic t_clear();
    clr_we = 1; clr_hi = 0; clr_data = 32'h0000_0020;
    @(negedge clk);
    clr_we = 0;
    m_pend[5] = 1'b0;
    check_all("R5 clear bit5");
    chk("R5 bit9 kept", 64'(pend_lo[9]), 64'd1);
    clr_we = 1; clr_hi = 1; clr_data = 32'h0000_0001;
    @(negedge clk);
    clr_we = 0;
    m_pend[32] = 1'b0;
    check_all("R5 clear high bit0");
  endtask

  task automatic t_set_wins();
    clr_we = 1; clr_hi = 0; clr_data = 32'h0000_0400;
    cmp_valid = 1; cmp_code = 6'd10; cmp_final = 1; opt_final_ien = 1;
    @(negedge clk);
    clr_we = 0; cmp_valid = 0; cmp_final = 0;
    m_pend[10] = 1'b1;
    chk("R6 set beats clear", 64'(pend_lo[10]), 64'd1);
  endtask

  task automatic t_persist();
    for (int i = 0; i < 5; i++) @(negedge clk);
    check_all("R9 level held");
    chk("R9 global still high", 64'(irq_global), 64'd1);
  endtask

  task automatic t_reeval();
    reeval = 1;
    @(negedge clk);
    reeval = 0;
    chk("R10 global blanked", 64'(irq_global), 64'd0);
    chk("R10 regions blanked", 64'(irq_region), 64'd0);
    @(negedge clk);
    check_all("R10 recovered");
  endtask

  initial begin
    for (int r = 0; r < NR; r++) m_mask[r] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_low_code();
    t_high_code();
    t_gating();
    t_enables();
    t_clear();
    t_set_wins();
    t_persist();
    t_reeval();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule